// File: doc/BRIEF.md
# Instruction Pre-Fetch Queue

This block sits between a slow program memory and the instruction fetch port of a CPU. It keeps a small queue of code bytes ahead of execution. Whenever the program-memory bus is free and the queue has room for another word, it reads the next 16-bit word without waiting for the CPU. Each memory access lasts a configurable number of wait-state clocks. The CPU takes one or two bytes per request. It is stalled only when the queue holds fewer bytes than it asked for.

A taken branch empties the queue and moves the fetch pointer to the branch target. If a fetch is on the bus when the branch arrives, that access runs to its end and its data is thrown away. An external branch cache that hits on the target can fill the whole queue in the branch cycle, and prefetching then continues four bytes past the target. When the enable input is low, the queue is bypassed: each CPU request starts one direct memory read, and the CPU waits for it to finish.

Top module: `code_prefetch_queue`

## Requirements
- R1: A memory word read at address A carries the byte at A in `mem_rdata[7:0]` and the byte at A+1 in `mem_rdata[15:8]`. A delivered two-byte request returns the byte at the CPU address in `cpu_data[7:0]` and the following byte in `cpu_data[15:8]`. A one-byte request returns its byte in `cpu_data[7:0]`. Consecutive deliveries advance through code in address order.
- R2: The queue never holds more than four bytes. A new prefetch starts only while the queue holds at most two bytes, so an idle CPU causes exactly two word fetches after the queue is emptied.
- R3: A fetch never starts in a cycle where `bus_hold` is high. `mem_addr` stays stable while `mem_rd` is high.
- R4: A fetch keeps `mem_rd` high for `cfg_wait` cycles, or for one cycle when `cfg_wait` is 0. The data is taken in the last of those cycles. The next fetch starts at the earliest one cycle later.
- R5: While enabled, a request is stalled exactly when the queue holds fewer bytes than requested (`cpu_len`: 0 means one byte, 1 means two bytes). A request that is not stalled is completed in the same cycle.
- R6: A cycle with `branch_valid` high empties the queue and stalls any CPU request in that cycle. The next fetch reads the branch target.
- R7: A fetch that is in progress when a branch arrives keeps `mem_rd` high until it ends, and its data never reaches the CPU.
- R8: A branch with `cache_fill` high loads the four bytes of `cache_bytes` into the queue in that cycle, with byte 0 in bits [7:0] standing at the target address. These bytes are delivered with no stall, and the next fetch reads the target plus 4.
- R9: During and right after reset, `mem_rd` is low and the queue is empty, so the first request stalls.
- R10: With `cfg_enable` low, no prefetch occurs. Each request starts one fetch at the CPU address and stalls for max(`cfg_wait`,1) cycles. The request is completed with the memory word in the cycle the fetch ends.
- R11: After a branch to an idle, enabled queue, a request held from the next cycle stalls for max(`cfg_wait`,1)+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Queue enable (low selects bypass mode) |
| cfg_wait | input | WAIT_W | Wait-state clocks per memory access |
| bus_hold | input | 1 | Program-memory bus taken by another master |
| branch_valid | input | 1 | Taken branch this cycle |
| branch_addr | input | ADDR_W | Branch target byte address |
| cache_fill | input | 1 | Branch cache hit, qualifies `cache_bytes` |
| cache_bytes | input | DEPTH*8 | Cached code bytes at the target, byte 0 lowest |
| cpu_req | input | 1 | CPU code request |
| cpu_len | input | 1 | Request size: 0 one byte, 1 two bytes |
| cpu_data | output | 16 | Code bytes returned to the CPU |
| cpu_stall | output | 1 | Request not served this cycle |
| mem_rd | output | 1 | Memory read in progress |
| mem_addr | output | ADDR_W | Byte address of the word being read |
| mem_rdata | input | 16 | Word returned by program memory |

## Verification
If the byte count or the fetch pointer is wrong, the next delivered byte has the wrong value. This shows up in the first request after the fault, or it shows up as a stall count that differs from the wait-state arithmetic. A lost discard flag shows up in the first bytes after a back-to-back branch: they come from the abandoned target. Wrong room logic shows up as a third bus read during an idle stretch, or as a missing refill that turns a predicted zero-stall request into a stall. The bench predicts every stall length from the configured wait states. It checks the byte values against an address-based memory pattern, so an error is caught within a few cycles of its cause.

// File: rtl/cpq_pkg.sv
package cpq_pkg;

  // Cycles a single memory access occupies the bus for a wait setting.
  function automatic int unsigned access_cycles(input int unsigned ws);
    return (ws == 0) ? 1 : ws;
  endfunction

  // True in the final cycle of an access, given cycles already spent.
  function automatic logic last_wait_cycle(input int unsigned spent, input int unsigned ws);
    return spent + 1 >= access_cycles(ws);
  endfunction

  // Bytes consumed by one CPU request.
  function automatic int unsigned req_bytes(input logic two);
    return two ? 2 : 1;
  endfunction

endpackage

// File: rtl/cpq_bytes.sv
module cpq_bytes #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               load,
  input  logic [DEPTH*8-1:0] load_data,
  input  logic [1:0]         pop_n,
  input  logic               push,
  input  logic [15:0]        push_word,
  output logic [CNT_W-1:0]   count,
  output logic [7:0]         head_lo,
  output logic [7:0]         head_hi
);

  logic [7:0]       slot_q [DEPTH];
  logic [7:0]       slot_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_left;

  always_comb begin
    cnt_left = cnt_q - CNT_W'(pop_n);
    cnt_d    = cnt_left;
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) slot_d[i] = slot_q[i + int'(pop_n)];
      else                         slot_d[i] = 8'h00;
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(cnt_left))     slot_d[i] = push_word[7:0];
        if (i == int'(cnt_left) + 1) slot_d[i] = push_word[15:8];
      end
      cnt_d = cnt_left + CNT_W'(2);
    end
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) slot_d[i] = 8'h00;
      cnt_d = '0;
    end
    if (load) begin
      for (int i = 0; i < DEPTH; i++) slot_d[i] = load_data[i*8 +: 8];
      cnt_d = CNT_W'(DEPTH);
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) slot_q[g] <= 8'h00;
        else        slot_q[g] <= slot_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign head_lo = slot_q[0];
  assign head_hi = slot_q[1];

endmodule

// File: rtl/cpq_fetch.sv
module cpq_fetch #(
  parameter int ADDR_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_byp,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic              branch,
  input  logic              enable,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              done_byp,
  output logic              keep
);
  import cpq_pkg::*;

  logic              busy_q, byp_q, drop_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WAIT_W-1:0] spent_q, wait_q;
  logic              drop_now;

  // Data is dropped on a branch, or when the mode no longer matches its tag.
  assign drop_now = branch || (byp_q == enable);
  assign done     = busy_q && last_wait_cycle(int'(spent_q), int'(wait_q));
  assign keep     = done && !drop_q && !drop_now;
  assign done_byp = byp_q;
  assign busy     = busy_q;
  assign addr     = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      byp_q   <= 1'b0;
      drop_q  <= 1'b0;
      addr_q  <= '0;
      spent_q <= '0;
      wait_q  <= '0;
    end else if (busy_q) begin
      if (drop_now) drop_q <= 1'b1;
      if (done) busy_q  <= 1'b0;
      else      spent_q <= spent_q + WAIT_W'(1);
    end else if (start) begin
      busy_q  <= 1'b1;
      byp_q   <= start_byp;
      drop_q  <= 1'b0;
      addr_q  <= start_addr;
      spent_q <= '0;
      wait_q  <= cfg_wait;
    end
  end

endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int WAIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               bus_hold,
  input  logic               branch_valid,
  input  logic [ADDR_W-1:0]  branch_addr,
  input  logic               cache_fill,
  input  logic [DEPTH*8-1:0] cache_bytes,
  input  logic               cpu_req,
  input  logic               cpu_len,
  output logic [15:0]        cpu_data,
  output logic               cpu_stall,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [15:0]        mem_rdata
);
  import cpq_pkg::*;

  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int ROOM_LIMIT = DEPTH - 2;

  // Named internal events
  logic [CNT_W-1:0]  q_count;
  logic [7:0]        head_lo, head_hi;
  logic              fetch_busy, fetch_done, fetch_byp, fetch_keep;
  logic              q_deliver, byp_deliver, deliver;
  logic              start_pf, start_bp, q_flush, q_load, q_push;
  logic [1:0]        pop_n;
  logic [CNT_W-1:0]  need_n;
  logic [ADDR_W-1:0] pc_q, start_addr;

  assign need_n      = CNT_W'(req_bytes(cpu_len));
  assign q_deliver   = cfg_enable && cpu_req && !branch_valid && (q_count >= need_n);
  assign byp_deliver = fetch_keep && fetch_byp && cpu_req;
  assign deliver     = q_deliver || byp_deliver;
  assign pop_n       = q_deliver ? 2'(req_bytes(cpu_len)) : 2'd0;
  assign q_push      = fetch_keep && !fetch_byp;
  assign q_flush     = branch_valid || !cfg_enable;
  assign q_load      = branch_valid && cache_fill && cfg_enable;

  assign start_pf = cfg_enable && !branch_valid && !fetch_busy && !bus_hold
                    && (int'(q_count) <= ROOM_LIMIT);
  assign start_bp = !cfg_enable && cpu_req && !branch_valid && !fetch_busy && !bus_hold;
  assign start_addr = start_bp ? pc_q : pc_q + ADDR_W'(q_count);

  cpq_bytes #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_bytes (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (q_flush),
    .load      (q_load),
    .load_data (cache_bytes),
    .pop_n     (pop_n),
    .push      (q_push),
    .push_word (mem_rdata),
    .count     (q_count),
    .head_lo   (head_lo),
    .head_hi   (head_hi)
  );

  cpq_fetch #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_pf || start_bp),
    .start_byp  (start_bp),
    .start_addr (start_addr),
    .cfg_wait   (cfg_wait),
    .branch     (branch_valid),
    .enable     (cfg_enable),
    .busy       (fetch_busy),
    .addr       (mem_addr),
    .done       (fetch_done),
    .done_byp   (fetch_byp),
    .keep       (fetch_keep)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            pc_q <= '0;
    else if (branch_valid) pc_q <= branch_addr;
    else if (deliver)      pc_q <= pc_q + ADDR_W'(req_bytes(cpu_len));
  end

  assign mem_rd    = fetch_busy;
  assign cpu_data  = byp_deliver ? mem_rdata : {head_hi, head_lo};
  assign cpu_stall = cpu_req && !deliver;

endmodule

// File: rtl/cpq_checks.sv
module cpq_checks #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              bus_hold,
  input logic              branch_valid,
  input logic              cpu_req,
  input logic              cpu_len,
  input logic              cpu_stall,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fetch_done,
  input logic [CNT_W-1:0]  q_count
);
  logic [CNT_W-1:0] need;
  assign need = cpu_len ? CNT_W'(2) : CNT_W'(1);

  // R3
  fetch_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> $past(!bus_hold));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_rd) && !$past(fetch_done)) |-> (mem_rd && $stable(mem_addr)));

  // R2
  queue_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= DEPTH);

  // R5
  short_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cpu_req && q_count < need) |-> cpu_stall);

  // R5
  ready_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cpu_req && !branch_valid && q_count >= need) |-> !cpu_stall);

  // R6
  branch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_valid && cpu_req) |-> cpu_stall);

  // R7
  flight_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_valid && mem_rd && !fetch_done) |=> mem_rd);

endmodule

bind code_prefetch_queue cpq_checks #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_enable   (cfg_enable),
  .bus_hold     (bus_hold),
  .branch_valid (branch_valid),
  .cpu_req      (cpu_req),
  .cpu_len      (cpu_len),
  .cpu_stall    (cpu_stall),
  .mem_rd       (mem_rd),
  .mem_addr     (mem_addr),
  .fetch_done   (fetch_done),
  .q_count      (q_count)
);

// File: tb/code_prefetch_queue_test.sv
module code_prefetch_queue_test;

  localparam int CLK_HALF = 10;   // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b1;
  logic [3:0]  cfg_wait = 4'd4;
  logic        bus_hold = 1'b0;
  logic        branch_valid = 1'b0;
  logic [15:0] branch_addr = '0;
  logic        cache_fill = 1'b0;
  logic [31:0] cache_bytes = '0;
  logic        cpu_req = 1'b0;
  logic        cpu_len = 1'b0;
  logic [15:0] cpu_data;
  logic        cpu_stall;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;

  int tests = 0;
  int fails = 0;
  int rises = 0;
  logic [15:0] last_addr = '0;
  logic rd_prev = 1'b0;
  logic [15:0] pc = '0;

  always #(CLK_HALF) clk = ~clk;

  code_prefetch_queue uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_wait(cfg_wait),
    .bus_hold(bus_hold), .branch_valid(branch_valid), .branch_addr(branch_addr),
    .cache_fill(cache_fill), .cache_bytes(cache_bytes), .cpu_req(cpu_req),
    .cpu_len(cpu_len), .cpu_data(cpu_data), .cpu_stall(cpu_stall),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] code_at(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_rdata = {code_at(mem_addr + 16'd1), code_at(mem_addr)};

  always @(posedge clk) begin
    if (mem_rd && !rd_prev) begin
      rises = rises + 1;
      last_addr = mem_addr;
    end
    rd_prev = mem_rd;
  end

  function automatic int bus_cycles(input logic [3:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Holds a request until served; returns stall count and data.
  task automatic pop(input logic two, output int stalls, output logic [15:0] d);
    stalls = 0;
    d = '0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      cpu_req = 1'b1;
      cpu_len = two;
      #5;
      if (!cpu_stall) begin
        d = cpu_data;
        break;
      end
      stalls++;
    end
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
  endtask

  // Pops and compares against the address pattern, advancing pc.
  task automatic pop_check(input logic two, input string req, output int stalls);
    logic [15:0] d, e;
    pop(two, stalls, d);
    e = two ? {code_at(pc + 16'd1), code_at(pc)} : {8'h00, code_at(pc)};
    if (!two) d[15:8] = 8'h00;
    chk(d == e, req, {16'h0, d}, {16'h0, e});
    pc = pc + (two ? 16'd2 : 16'd1);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic branch_to(input logic [15:0] a, input logic fill, input logic [31:0] bytes);
    @(negedge clk);
    branch_valid = 1'b1;
    branch_addr  = a;
    cache_fill   = fill;
    cache_bytes  = bytes;
    @(posedge clk);
    #1;
    branch_valid = 1'b0;
    cache_fill   = 1'b0;
    pc = a;
  endtask

  // {wait, target, request sizes}
  localparam logic [23:0] VEC [6] = '{
    {4'd4, 16'h0100, 4'b1010},
    {4'd0, 16'h0203, 4'b1111},
    {4'd1, 16'h7FF1, 4'b0000},
    {4'd5, 16'hFFFE, 4'b0110},
    {4'd7, 16'h1234, 4'b1001},
    {4'd2, 16'h00FF, 4'b0011}
  };

  task automatic run_all();
    int st, r0;
    logic [15:0] d;

    // Reset state (R9)
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #5;
      chk(mem_rd == 1'b0, "R9 mem_rd in reset", {31'h0, mem_rd}, 32'h0);
    end
    @(negedge clk);
    rst_n   = 1'b1;
    cpu_req = 1'b1;
    cpu_len = 1'b0;
    #5;
    chk(cpu_stall == 1'b1, "R9 first request stalls", {31'h0, cpu_stall}, 32'h1);
    @(posedge clk);
    #1;
    cpu_req = 1'b0;

    // Idle fill: exactly two words (R2)
    idle(40);
    chk(rises == 2, "R2 idle fetch count", rises, 2);
    pop_check(1'b1, "R1 first pair", st);
    chk(st == 0, "R5 full queue no stall", st, 0);
    pop_check(1'b1, "R1 second pair", st);
    chk(st == 0, "R5 full queue no stall", st, 0);
    pop_check(1'b1, "R1 third pair", st);
    chk(st == bus_cycles(cfg_wait), "R4 refill latency", st, bus_cycles(cfg_wait));

    // Vector table: wait settings, targets, request sizes (R11, R1, R4)
    for (int v = 0; v < 6; v++) begin
      idle(12 * 8 + 10);
      @(negedge clk);
      cfg_wait = VEC[v][23:20];
      branch_to(VEC[v][19:4], 1'b0, 32'h0);
      pop_check(VEC[v][3], "R11 branch data", st);
      chk(st == bus_cycles(cfg_wait) + 1, "R11 branch latency", st, bus_cycles(cfg_wait) + 1);
      for (int p = 2; p >= 0; p--) pop_check(VEC[v][p], "R1 stream data", st);
    end
    @(negedge clk);
    cfg_wait = 4'd4;
    idle(60);

    // Bus hold blocks fetch start (R3)
    @(negedge clk);
    bus_hold = 1'b1;
    branch_to(16'h4000, 1'b0, 32'h0);
    r0 = rises;
    idle(20);
    #5;
    chk(rises == r0, "R3 no fetch under hold", rises, r0);
    chk(mem_rd == 1'b0, "R3 mem_rd low under hold", {31'h0, mem_rd}, 32'h0);
    bus_hold = 1'b0;
    pop_check(1'b1, "R3 data after hold", st);

    // Branch during fetch: completes, data dropped (R7, R6)
    idle(60);
    branch_to(16'h5000, 1'b0, 32'h0);
    idle(1);
    branch_to(16'h6000, 1'b0, 32'h0);
    @(negedge clk);
    #5;
    chk(mem_rd == 1'b1, "R7 access continues", {31'h0, mem_rd}, 32'h1);
    pop_check(1'b1, "R7 stale data dropped", st);
    chk(last_addr == 16'h6000, "R6 fetch at target", {16'h0, last_addr}, 32'h6000);

    // Cache fill (R8)
    idle(60);
    branch_to(16'h7000, 1'b1, 32'h44332211);
    pop(1'b1, st, d);
    chk(d == 16'h2211 && st == 0, "R8 cached bytes 0-1", {st[15:0], d}, 32'h2211);
    pop(1'b1, st, d);
    chk(d == 16'h4433 && st == 0, "R8 cached bytes 2-3", {st[15:0], d}, 32'h4433);
    pc = 16'h7004;
    pop_check(1'b0, "R8 data past cache line", st);
    chk(last_addr == 16'h7004, "R8 next fetch address", {16'h0, last_addr}, 32'h7004);

    // Branch cycle stalls a request (R6)
    idle(60);
    @(negedge clk);
    branch_valid = 1'b1;
    branch_addr  = 16'h0800;
    cpu_req      = 1'b1;
    cpu_len      = 1'b0;
    #5;
    chk(cpu_stall == 1'b1, "R6 stall in branch cycle", {31'h0, cpu_stall}, 32'h1);
    @(posedge clk);
    #1;
    branch_valid = 1'b0;
    cpu_req      = 1'b0;
    pc = 16'h0800;
    pop_check(1'b1, "R6 data at target", st);

    // Bypass mode (R10)
    idle(60);
    @(negedge clk);
    cfg_enable = 1'b0;
    idle(3);
    r0 = rises;
    pop_check(1'b1, "R10 bypass word", st);
    chk(st == bus_cycles(cfg_wait), "R10 bypass stall", st, bus_cycles(cfg_wait));
    chk(rises == r0 + 1, "R10 one fetch per request", rises, r0 + 1);
    idle(15);
    chk(rises == r0 + 1, "R10 no prefetch when disabled", rises, r0 + 1);
    pop_check(1'b0, "R10 bypass byte", st);
    chk(st == bus_cycles(cfg_wait), "R10 bypass stall", st, bus_cycles(cfg_wait));
    @(negedge clk);
    cfg_enable = 1'b1;
    pop_check(1'b1, "R10 data after re-enable", st);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        #(200000 * 2 * CLK_HALF);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule